// File: doc/BRIEF.md
# Serial EEPROM Slave (256 bytes, SPI mode 0)

This block models a small serial EEPROM behind an SPI slave port. The array holds 256 bytes in ordinary registers. A host selects the device with an active-low select, shifts in an 8-bit instruction and then talks to the array. There are three instructions. Read streams bytes out from any address and keeps going for as long as the host clocks. Write fills a four-byte page buffer. Write-enable arms a latch that every write needs.

A write is all-or-nothing. The buffered bytes reach the array in one cycle, and only when select is released on a whole-byte boundary that lies between one and four data bytes. Any other release throws the buffer away. A hold input lets the host park a transfer in the middle of a byte: the output floats and clock edges are ignored until hold is released.

All pins are sampled with the system clock `clk_i`. The host's SPI clock must therefore stay in each level for at least two `clk_i` periods.

Top module: `ee_spi_slave`

## Requirements
- R1: `so_oe_o` is 0 whenever `cs_ni` is high. It is also 0 during the instruction and address phases of every transfer. It goes to 1 only in the data phase of a read.
- R2: Instruction 0x03, then an address byte A, makes the block shift out memory[A] MSB first. Bit 7 appears after the falling SCK edge that follows the 16th rising edge. Each following bit appears after the next falling edge, so the host samples on rising edges 17 onward.
- R3: During a read the address advances by one after each byte. It wraps from 0xFF to 0x00, and the stream never ends while clocks continue.
- R4: Instruction 0x06 sets the write-enable latch only when `cs_ni` rises after exactly 8 rising SCK edges. One extra edge before deselect leaves the latch clear.
- R5: A write (instruction 0x02, address, data) with the latch clear leaves memory unchanged.
- R6: With the latch set, a write reaches the array only when `cs_ni` rises after exactly 24, 32, 40 or 48 rising edges. A rise at any other count, including mid-byte or after a fifth data byte, leaves memory unchanged.
- R7: Write data goes to address bits [1:0] starting at the given offset and increments modulo 4 inside the page given by bits [7:2]. Only the bytes actually received are updated; the other bytes of the page keep their values.
- R8: A committed write clears the write-enable latch. A second write without a new 0x06 has no effect.
- R9: While `hold_ni` is low (asserted with SCK low), `so_oe_o` is 0 and SCK/SI edges are ignored. After release the transfer resumes at the same bit.
- R10: An instruction other than 0x02, 0x03 or 0x06 makes the block ignore all further bits until `cs_ni` goes high. A read instruction sent later in that same selection produces no output.
- R11: The array changes only in the cycle in which a write commits.
- R12: After reset every byte reads 0x00, the latch is clear and `so_oe_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; all pins are sampled on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Active-low chip select |
| sck_i | input | 1 | Serial clock from the host (idles low) |
| si_i | input | 1 | Serial data in, captured on rising SCK |
| hold_ni | input | 1 | Active-low transfer pause |
| so_o | output | 1 | Serial data out, updated after falling SCK |
| so_oe_o | output | 1 | Output enable for the tri-state SO driver |

## Verification
Two events can land in the same system-clock cycle: the rise of select that decides whether a write commits, and the edge that completes the last data byte. They meet when the host releases select right after the final rising SCK edge. The bench provokes this for every start offset with one to four bytes, and also releases early (mid-byte) and late (a fifth byte). It judges the result only by reading the page back through the read instruction and comparing it with a model of the array kept in the bench. A second overlap, hold arriving in the middle of a read byte, is judged by whether the byte reassembled after release matches the model.

// File: rtl/ee_pkg.sv
package ee_pkg;
  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] OPC_WREN  = 8'h06;
  localparam logic [BYTE_W-1:0] OPC_READ  = 8'h03;
  localparam logic [BYTE_W-1:0] OPC_WRITE = 8'h02;

  typedef enum logic [2:0] {
    ST_CMD,
    ST_ADDR,
    ST_RD,
    ST_WR,
    ST_WEN,
    ST_IGN
  } ee_state_e;
endpackage

// File: rtl/ee_spi_edges.sv
// Pin sampling: SCK edge strobes, select release, hold state.
module ee_spi_edges (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sck_i,
  input  logic hold_ni,
  output logic sck_rise_o,
  output logic sck_fall_o,
  output logic cs_rise_o,
  output logic held_o
);
  logic sck_q, cs_q, held_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q  <= 1'b0;
      cs_q   <= 1'b1;
      held_q <= 1'b0;
    end else begin
      sck_q <= sck_i;
      cs_q  <= cs_ni;
      if (cs_ni)       held_q <= 1'b0;
      else if (!sck_i) held_q <= !hold_ni;  // hold changes only while SCK low
    end
  end

  assign sck_rise_o = !cs_ni && !held_q &&  sck_i && !sck_q;
  assign sck_fall_o = !cs_ni && !held_q && !sck_i &&  sck_q;
  assign cs_rise_o  =  cs_ni && !cs_q;
  assign held_o     = held_q;
endmodule

// File: rtl/ee_bit_cnt.sv
// Counts rising SCK edges per selection and assembles incoming bytes.
module ee_bit_cnt #(
  parameter int CNT_W = 7
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      cs_ni,
  input  logic                      sck_rise_i,
  input  logic                      si_i,
  output logic [CNT_W-1:0]          cnt_o,
  output logic                      byte_done_o,
  output logic [ee_pkg::BYTE_W-1:0] rx_byte_o
);
  localparam int BYTE_W = ee_pkg::BYTE_W;
  localparam int BIT_W  = $clog2(BYTE_W);

  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] rx_q;
  logic              sat;

  assign sat = &cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      rx_q  <= '0;
    end else if (cs_ni) begin
      cnt_q <= '0;
    end else if (sck_rise_i) begin
      rx_q <= rx_byte_o;
      if (!sat) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign rx_byte_o   = {rx_q[BYTE_W-2:0], si_i};
  assign byte_done_o = sck_rise_i && !sat && (&cnt_q[BIT_W-1:0]);
  assign cnt_o       = cnt_q;
endmodule

// File: rtl/ee_page_buf.sv
// Holds write data for one page with per-byte valid flags.
module ee_page_buf #(
  parameter int PAGE_W = 2
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              clr_i,
  input  logic                              wr_i,
  input  logic [PAGE_W-1:0]                 idx_i,
  input  logic [ee_pkg::BYTE_W-1:0]         data_i,
  output logic [(1<<PAGE_W)*ee_pkg::BYTE_W-1:0] buf_o,
  output logic [(1<<PAGE_W)-1:0]            valid_o
);
  localparam int BYTE_W     = ee_pkg::BYTE_W;
  localparam int PAGE_BYTES = 1 << PAGE_W;

  logic [PAGE_BYTES*BYTE_W-1:0] buf_q;
  logic [PAGE_BYTES-1:0]        valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q   <= '0;
      valid_q <= '0;
    end else if (clr_i) begin
      valid_q <= '0;
    end else if (wr_i) begin
      buf_q[idx_i*BYTE_W +: BYTE_W] <= data_i;  // page wrap overwrites earlier byte
      valid_q[idx_i]                <= 1'b1;
    end
  end

  assign buf_o   = buf_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/ee_mem_array.sv
// Register array: one async read port, page-wide commit port.
module ee_mem_array #(
  parameter int ADDR_W = 8,
  parameter int PAGE_W = 2
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic                                  commit_i,
  input  logic [ADDR_W-PAGE_W-1:0]              page_i,
  input  logic [(1<<PAGE_W)*ee_pkg::BYTE_W-1:0] buf_i,
  input  logic [(1<<PAGE_W)-1:0]                valid_i,
  input  logic [ADDR_W-1:0]                     rd_addr_i,
  output logic [ee_pkg::BYTE_W-1:0]             rd_data_o,
  output logic [(1<<ADDR_W)*ee_pkg::BYTE_W-1:0] mem_flat_o
);
  localparam int BYTE_W     = ee_pkg::BYTE_W;
  localparam int DEPTH      = 1 << ADDR_W;
  localparam int PAGE_BYTES = 1 << PAGE_W;

  logic [BYTE_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (commit_i) begin
      for (int i = 0; i < PAGE_BYTES; i++)
        if (valid_i[i]) mem_q[{page_i, PAGE_W'(i)}] <= buf_i[i*BYTE_W +: BYTE_W];
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];

  for (genvar g = 0; g < DEPTH; g++) begin : g_flat
    assign mem_flat_o[g*BYTE_W +: BYTE_W] = mem_q[g];
  end
endmodule

// File: rtl/ee_spi_slave.sv
module ee_spi_slave #(
  parameter int ADDR_W = 8,
  parameter int PAGE_W = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sck_i,
  input  logic si_i,
  input  logic hold_ni,
  output logic so_o,
  output logic so_oe_o
);
  import ee_pkg::*;

  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int BIT_W      = $clog2(BYTE_W);
  localparam int MIN_CLK    = 3 * BYTE_W;
  localparam int MAX_CLK    = (2 + PAGE_BYTES) * BYTE_W;
  localparam int CNT_W      = $clog2(MAX_CLK + 1) + 1;
  localparam int MEM_BITS   = (1 << ADDR_W) * BYTE_W;

  logic sck_rise, sck_fall, cs_rise, held;
  logic [CNT_W-1:0]  clk_cnt;
  logic              byte_done;
  logic [BYTE_W-1:0] rx_byte;

  ee_state_e state_q;
  logic                     rd_mode_q, rd_live_q, wel_q, so_q;
  logic [ADDR_W-1:0]        ptr_q;
  logic [ADDR_W-PAGE_W-1:0] wr_page_q;
  logic [PAGE_W-1:0]        wr_off_q;
  logic [BYTE_W-1:0]        tx_q;
  logic [BIT_W-1:0]         tx_cnt_q;

  logic [PAGE_BYTES*BYTE_W-1:0] pbuf;
  logic [PAGE_BYTES-1:0]        pvalid;
  logic [ADDR_W-1:0]            rd_addr;
  logic [BYTE_W-1:0]            rd_data;
  logic [MEM_BITS-1:0]          mem_flat;
  logic                         cnt_legal, commit, wen_ok, buf_wr;

  ee_spi_edges i_edges (
    .clk_i, .rst_ni, .cs_ni, .sck_i, .hold_ni,
    .sck_rise_o(sck_rise), .sck_fall_o(sck_fall),
    .cs_rise_o(cs_rise), .held_o(held)
  );

  ee_bit_cnt #(.CNT_W(CNT_W)) i_bit_cnt (
    .clk_i, .rst_ni, .cs_ni,
    .sck_rise_i(sck_rise), .si_i,
    .cnt_o(clk_cnt), .byte_done_o(byte_done), .rx_byte_o(rx_byte)
  );

  assign buf_wr = byte_done && (state_q == ST_WR);

  ee_page_buf #(.PAGE_W(PAGE_W)) i_page_buf (
    .clk_i, .rst_ni, .clr_i(cs_ni), .wr_i(buf_wr),
    .idx_i(wr_off_q), .data_i(rx_byte),
    .buf_o(pbuf), .valid_o(pvalid)
  );

  assign rd_addr = (state_q == ST_RD) ? ptr_q : rx_byte[ADDR_W-1:0];

  ee_mem_array #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) i_mem (
    .clk_i, .rst_ni, .commit_i(commit), .page_i(wr_page_q),
    .buf_i(pbuf), .valid_i(pvalid), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .mem_flat_o(mem_flat)
  );

  // whole-byte boundary with one to PAGE_BYTES data bytes
  assign cnt_legal = (clk_cnt >= CNT_W'(MIN_CLK)) && (clk_cnt <= CNT_W'(MAX_CLK))
                   && (clk_cnt[BIT_W-1:0] == '0);
  assign commit    = cs_rise && (state_q == ST_WR) && wel_q && cnt_legal;
  assign wen_ok    = cs_rise && (state_q == ST_WEN) && (clk_cnt == CNT_W'(BYTE_W));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      wel_q <= 1'b0;
    else if (commit)  wel_q <= 1'b0;
    else if (wen_ok)  wel_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_CMD;
      rd_mode_q <= 1'b0;
      rd_live_q <= 1'b0;
      so_q      <= 1'b0;
      ptr_q     <= '0;
      wr_page_q <= '0;
      wr_off_q  <= '0;
      tx_q      <= '0;
      tx_cnt_q  <= '0;
    end else if (cs_ni) begin
      state_q   <= ST_CMD;
      rd_mode_q <= 1'b0;
      rd_live_q <= 1'b0;
    end else begin
      if (byte_done) begin
        case (state_q)
          ST_CMD: begin
            if (rx_byte == OPC_WREN) begin
              state_q <= ST_WEN;
            end else if (rx_byte == OPC_READ) begin
              state_q   <= ST_ADDR;
              rd_mode_q <= 1'b1;
            end else if (rx_byte == OPC_WRITE) begin
              state_q   <= ST_ADDR;
              rd_mode_q <= 1'b0;
            end else begin
              state_q <= ST_IGN;
            end
          end
          ST_ADDR: begin
            if (rd_mode_q) begin
              state_q  <= ST_RD;
              tx_q     <= rd_data;
              ptr_q    <= rx_byte[ADDR_W-1:0] + 1'b1;
              tx_cnt_q <= '0;
            end else begin
              state_q   <= ST_WR;
              wr_page_q <= rx_byte[ADDR_W-1:PAGE_W];
              wr_off_q  <= rx_byte[PAGE_W-1:0];
            end
          end
          ST_WR:   wr_off_q <= wr_off_q + 1'b1;
          default: ;
        endcase
      end
      if (sck_rise && state_q == ST_WEN) state_q <= ST_IGN;
      if (sck_fall && state_q == ST_RD) begin
        so_q      <= tx_q[BYTE_W-1];
        rd_live_q <= 1'b1;
        tx_cnt_q  <= tx_cnt_q + 1'b1;
        if (&tx_cnt_q) begin
          tx_q  <= rd_data;
          ptr_q <= ptr_q + 1'b1;
        end else begin
          tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
        end
      end
    end
  end

  assign so_o    = so_q;
  assign so_oe_o = rd_live_q && !cs_ni && !held;
endmodule

// File: rtl/ee_spi_checker.sv
module ee_spi_checker #(
  parameter int CNT_W    = 7,
  parameter int MEM_BITS = 2048
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                cs_ni,
  input logic                sck_i,
  input logic                hold_ni,
  input logic                so_oe_o,
  input logic                commit,
  input logic                wel,
  input logic                held,
  input logic [CNT_W-1:0]    clk_cnt,
  input logic [MEM_BITS-1:0] mem_flat
);
  a_r1_float_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni && $past(cs_ni)) |-> !so_oe_o);

  a_r9_hold_floats_so: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(!hold_ni) && $past(!sck_i) && $past(!cs_ni) && !cs_ni) |-> !so_oe_o);

  a_r9_hold_freezes_cnt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (held && !cs_ni) |=> $stable(clk_cnt));

  a_r5_commit_needs_wel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit |-> wel);

  a_r8_commit_clears_wel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit |=> !wel);

  a_r6_commit_on_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit |-> (cs_ni && !$past(cs_ni)));

  a_r4_wel_set_on_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wel) |-> $past(cs_ni));

  a_r11_mem_only_on_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit |=> $stable(mem_flat));
endmodule

bind ee_spi_slave ee_spi_checker #(.CNT_W(CNT_W), .MEM_BITS(MEM_BITS)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_ni(cs_ni), .sck_i(sck_i),
  .hold_ni(hold_ni), .so_oe_o(so_oe_o), .commit(commit), .wel(wel_q),
  .held(held), .clk_cnt(clk_cnt), .mem_flat(mem_flat)
);

// File: tb/test_ee_spi_slave.sv
module test_ee_spi_slave;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 2;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cs_ni = 1'b1, sck = 1'b0, si = 1'b0, hold_ni = 1'b1;
  logic so_o, so_oe_o;
  int   checks = 0, errors = 0;
  logic [7:0] exp_mem [256];

  always #(CLK_PERIOD/2) clk = ~clk;

  ee_spi_slave i_ee_spi_slave (
    .clk_i(clk), .rst_ni, .cs_ni, .sck_i(sck), .si_i(si),
    .hold_ni, .so_o, .so_oe_o
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic bit_x(input logic b, output logic s, output logic oe);
    @(negedge clk) si = b;
    repeat (HALF) @(negedge clk);
    s  = so_o;
    oe = so_oe_o;
    sck = 1'b1;
    repeat (HALF) @(negedge clk);
    sck = 1'b0;
  endtask

  task automatic byte_x(input logic [7:0] b, output logic [7:0] r,
                        output logic oe_all, output logic oe_any);
    logic s, oe;
    oe_all = 1'b1; oe_any = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      bit_x(b[i], s, oe);
      r[i] = s; oe_all &= oe; oe_any |= oe;
    end
  endtask

  task automatic sel();
    @(negedge clk) cs_ni = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic desel();
    repeat (HALF) @(negedge clk);
    cs_ni = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b, input string req);
    logic [7:0] r; logic all, any;
    byte_x(b, r, all, any);
    chk(!any, req, any, 0);
  endtask

  task automatic wren();
    sel(); send(8'h06, "R1 wren phase"); desel();
  endtask

  function automatic logic [7:0] pat(input logic [7:0] seed, input int i);
    return seed + 8'(i * 29) ^ 8'h3C;
  endfunction

  task automatic do_write(input logic [7:0] a, input int n, input logic [7:0] seed);
    sel(); send(8'h02, "R1 wr op"); send(a, "R1 wr addr");
    for (int i = 0; i < n; i++) send(pat(seed, i), "R1 wr data");
    desel();
  endtask

  task automatic model_write(input logic [7:0] a, input int n, input logic [7:0] seed);
    for (int i = 0; i < n; i++) exp_mem[{a[7:2], 2'(a[1:0] + i)}] = pat(seed, i);
  endtask

  task automatic read_chk(input logic [7:0] a, input int n, input string req);
    logic [7:0] r; logic all, any;
    sel(); send(8'h03, "R1 rd op"); send(a, "R1 rd addr");
    for (int i = 0; i < n; i++) begin
      byte_x(8'h00, r, all, any);
      chk(r == exp_mem[8'(a + i)], req, r, exp_mem[8'(a + i)]);
      chk(all, "R2 oe in data phase", all, 1);
    end
    desel();
    chk(!so_oe_o, "R1 oe after deselect", so_oe_o, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
  end

  initial begin
    logic [7:0] r; logic s, oe, all, any;
    for (int i = 0; i < 256; i++) exp_mem[i] = 8'h00;
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);

    // R12: reset state
    chk(!so_oe_o, "R12 oe at reset", so_oe_o, 0);
    read_chk(8'h00, 4, "R12 zero contents");

    // R5: write with latch clear
    do_write(8'h40, 1, 8'hAA);
    read_chk(8'h40, 4, "R5 write without latch");

    // R6/R7: every start offset with 1..4 bytes, release on the boundary
    for (int off = 0; off < 4; off++)
      for (int n = 1; n <= 4; n++) begin
        logic [7:0] a;
        a = 8'((16 + off * 4 + n) * 4 + off);
        // pre-fill the whole page so untouched bytes are distinguishable
        wren(); do_write({a[7:2], 2'b00}, 4, 8'h11); model_write({a[7:2], 2'b00}, 4, 8'h11);
        wren(); do_write(a, n, 8'(off * 16 + n)); model_write(a, n, 8'(off * 16 + n));
        read_chk({a[7:2], 2'b00}, 4, "R7 page wrap and partial update");
      end

    // R6: five data bytes (56 clocks) aborts
    wren(); do_write(8'h20, 5, 8'h77);
    read_chk(8'h20, 4, "R6 abort after fifth byte");

    // R6: release mid-byte (28 clocks) aborts
    wren();
    sel(); send(8'h02, "R1 op"); send(8'h24, "R1 addr"); send(8'h99, "R1 data");
    for (int i = 0; i < 4; i++) bit_x(1'b1, s, oe);
    desel();
    read_chk(8'h24, 4, "R6 abort mid-byte");

    // R8: commit clears the latch
    wren(); do_write(8'h30, 2, 8'h5E); model_write(8'h30, 2, 8'h5E);
    do_write(8'h30, 2, 8'hE5);
    read_chk(8'h30, 4, "R8 latch cleared by commit");

    // R4: a ninth clock before deselect leaves the latch clear
    sel(); send(8'h06, "R1 op"); bit_x(1'b0, s, oe); desel();
    do_write(8'h34, 1, 8'hC3);
    read_chk(8'h34, 4, "R4 wren with extra clock");

    // R10: unknown opcode, then a read opcode in the same selection
    sel(); send(8'h05, "R10 unknown op");
    send(8'h03, "R10 later read op"); send(8'h30, "R10 later addr");
    byte_x(8'h00, r, all, any);
    chk(!any, "R10 no output after unknown op", any, 0);
    desel();

    // R3: wrap from 0xFF to 0x00
    wren(); do_write(8'h00, 4, 8'h81); model_write(8'h00, 4, 8'h81);
    wren(); do_write(8'hFC, 4, 8'h42); model_write(8'hFC, 4, 8'h42);
    read_chk(8'hFE, 6, "R3 wrap at top");
    read_chk(8'h05, 260, "R3 full-space stream");

    // R9: hold in the middle of a read byte
    sel(); send(8'h03, "R1 op"); send(8'h01, "R1 addr");
    for (int i = 7; i >= 0; i--) begin
      if (i == 3) begin
        @(negedge clk) hold_ni = 1'b0;
        repeat (3) @(negedge clk);
        chk(!so_oe_o, "R9 oe during hold", so_oe_o, 0);
        for (int k = 0; k < 3; k++) begin
          si = k[0]; sck = 1'b1; repeat (HALF) @(negedge clk);
          sck = 1'b0; repeat (HALF) @(negedge clk);
          chk(!so_oe_o, "R9 oe while clocking in hold", so_oe_o, 0);
        end
        hold_ni = 1'b1;
        repeat (3) @(negedge clk);
      end
      bit_x(1'b0, s, oe);
      r[i] = s;
    end
    chk(r == exp_mem[1], "R9 byte resumes after hold", r, exp_mem[1]);
    byte_x(8'h00, r, all, any);
    chk(r == exp_mem[2], "R9 next byte after hold", r, exp_mem[2]);
    desel();

    // R11: aborted and ignored operations left earlier data intact
    read_chk(8'h30, 8, "R11 array unchanged");

    summary();
  end
endmodule